// File: doc/BRIEF.md
# Power-State Clock Gating Window Controller

This block decides when the internal clocks of a link device may be stopped while the system sits in a low-power state. It watches two decoded broadcast events. The first is a stop-grant message that carries a 3-bit action code. The second is a stop-clock release message. It also watches an active-low link-stop input that arrives from outside the clock domain. A software-written enable mask, with one bit for each action code, chooses which stop-grant messages may arm gating.

A stop-grant whose code is enabled opens a gating window. If link-stop is then asserted while the window is open, the block first holds off new upstream requests and then drops its clock-enable output. When link-stop is released, the clock enable comes back, and the upstream hold is lifted one cycle later. Only one link-stop assertion is gated per window. A stop-clock release message or a stop-grant with a disabled code closes the window without gating. The clock-enable output stands in for the actual gating cell.

Top module: `cgw_ctrl`

## Requirements
- R1: After reset `clk_en` is 1, `upstream_hold` is 0 and the enable mask is all zeros, so no stop-grant can open a window until the mask is written.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the enable mask. Bit i of the mask enables stop-grant action code i. A stop-grant in the same cycle as a write is judged against the old mask.
- R3: A stop-grant (`sg_valid` high) whose `sg_action` bit is set in the mask opens the window. A later link-stop assertion (`link_stop_n` low) then gates the clocks (`clk_en` = 0).
- R4: A stop-grant whose action bit is clear in the mask never opens a window. When the window is open and no link-stop is seen, such a stop-grant closes the window.
- R5: A stop-clock release message (`scd_valid` high) closes an open window before any gating. If an enabling stop-grant and a release arrive in the same cycle, the window stays closed.
- R6: While no window is open, link-stop assertions leave `clk_en` at 1 and `upstream_hold` at 0.
- R7: `link_stop_n` passes through a 2-stage synchronizer. When it falls with the window open and is sampled low, `upstream_hold` rises after the 3rd rising clock edge that follows, and `clk_en` falls one edge later. `upstream_hold` is high in every cycle in which `clk_en` is 0.
- R8: When `link_stop_n` returns high, `clk_en` rises after the 3rd rising edge that follows, and `upstream_hold` falls one edge after that.
- R9: After a gated link-stop assertion ends, the window is closed. A further link-stop assertion is not gated until a new enabling stop-grant arrives.
- R10: A release message that arrives while the hold or gating is active does not end the gating early. Gating ends only when link-stop is released, and the window is closed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_wdata | input | 8 | New enable mask, one bit per action code |
| sg_valid | input | 1 | Decoded stop-grant broadcast, one-cycle pulse |
| sg_action | input | 3 | Action code carried by the stop-grant |
| scd_valid | input | 1 | Decoded stop-clock release broadcast, one-cycle pulse |
| link_stop_n | input | 1 | Asynchronous active-low link-stop |
| clk_en | output | 1 | Clock enable to the gating cell, 0 = clocks stopped |
| upstream_hold | output | 1 | Holds off new upstream requests |

## Verification
A cycle-accurate reference model in the bench follows the window through each event ordering. These orderings are: a disabled code after an enabling one, a release message before link-stop, a release in the same cycle as an enabling stop-grant, a release during gating, and a second link-stop with no new stop-grant. A design that let a later message win a same-cycle tie would gate when it should not. A design that forgot to close the window after the first gated assertion would gate the second link-stop. A design that let a release message end gating early would restart the clocks while link-stop is still low. The hold timing is checked at the exact edges on both sides of gating, so a synchronizer one stage short, or a hold that rises together with the gate, would show up as a mismatch in that cycle.

// File: rtl/cgw_pkg.sv
package cgw_pkg;
   typedef enum logic [2:0] {
      ST_CLOSED = 3'd0,
      ST_ARMED  = 3'd1,
      ST_PRE    = 3'd2,
      ST_GATED  = 3'd3,
      ST_POST   = 3'd4
   } cgw_state_e;
endpackage

// File: rtl/cgw_sync.sv
module cgw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d_async;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async};
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cgw_mask.sv
module cgw_mask #(
   parameter int ACT_W  = 3,
   parameter int MASK_W = 1 << ACT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MASK_W-1:0] wr_data,
   input  logic              ev_valid,
   input  logic [ACT_W-1:0]  ev_code,
   output logic              ev_hit,
   output logic [MASK_W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (wr_en) mask_q <= wr_data;
   end

   // judged against the mask as it stood before any same-cycle write
   assign ev_hit = ev_valid & mask_q[ev_code];
endmodule

// File: rtl/cgw_fsm.sv
module cgw_fsm
   import cgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_act,
   input  logic       sg_seen,
   input  logic       sg_hit,
   input  logic       rel_seen,
   output cgw_state_e st_q,
   output logic       gate_en,
   output logic       hold_req
);
   cgw_state_e st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_CLOSED: if (sg_hit && !rel_seen) st_d = ST_ARMED;
         ST_ARMED: begin
            if (rel_seen)                 st_d = ST_CLOSED;
            else if (stop_act)            st_d = ST_PRE;
            else if (sg_seen && !sg_hit)  st_d = ST_CLOSED;
         end
         ST_PRE:   st_d = ST_GATED;
         ST_GATED: if (!stop_act) st_d = ST_POST;
         ST_POST:  st_d = ST_CLOSED;
         default:  st_d = ST_CLOSED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_CLOSED;
      else        st_q <= st_d;
   end

   assign gate_en  = (st_q != ST_GATED);
   assign hold_req = (st_q == ST_PRE) || (st_q == ST_GATED) || (st_q == ST_POST);
endmodule

// File: rtl/cgw_ctrl.sv
module cgw_ctrl
   import cgw_pkg::*;
#(
   parameter int ACT_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int MASK_W     = 1 << ACT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [MASK_W-1:0] cfg_wdata,
   input  logic              sg_valid,
   input  logic [ACT_W-1:0]  sg_action,
   input  logic              scd_valid,
   input  logic              link_stop_n,
   output logic              clk_en,
   output logic              upstream_hold
);
   generate
      if (ACT_W < 1 || ACT_W > 6) begin : g_bad_act
         $error("cgw_ctrl: ACT_W must lie in 1..6");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cgw_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              stop_sync;
   logic              sg_hit;
   logic [MASK_W-1:0] cfg_mask;
   cgw_state_e        st;

   cgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (~link_stop_n),
      .q_sync  (stop_sync)
   );

   cgw_mask #(.ACT_W(ACT_W), .MASK_W(MASK_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_data  (cfg_wdata),
      .ev_valid (sg_valid),
      .ev_code  (sg_action),
      .ev_hit   (sg_hit),
      .mask_q   (cfg_mask)
   );

   cgw_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_act (stop_sync),
      .sg_seen  (sg_valid),
      .sg_hit   (sg_hit),
      .rel_seen (scd_valid),
      .st_q     (st),
      .gate_en  (clk_en),
      .hold_req (upstream_hold)
   );
endmodule

module cgw_ctrl_chk
   import cgw_pkg::*;
#(
   parameter int MASK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [MASK_W-1:0] cfg_wdata,
   input logic [MASK_W-1:0] mask,
   input logic              scd_valid,
   input logic              stop_sync,
   input cgw_state_e        st,
   input logic              clk_en,
   input logic              upstream_hold
);
   p_hold_covers_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> upstream_hold);

   p_hold_leads_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> $past(upstream_hold));

   p_hold_trails_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> upstream_hold);

   p_gate_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> $past(stop_sync, 2));

   p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (mask == $past(cfg_wdata)));

   p_release_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scd_valid && (st == ST_CLOSED || st == ST_ARMED)) |=> (st == ST_CLOSED));

   p_single_use_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POST) |=> (st == ST_CLOSED));

   p_closed_no_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CLOSED) |=> clk_en);
endmodule

bind cgw_ctrl cgw_ctrl_chk #(.MASK_W(MASK_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_we        (cfg_we),
   .cfg_wdata     (cfg_wdata),
   .mask          (cfg_mask),
   .scd_valid     (scd_valid),
   .stop_sync     (stop_sync),
   .st            (st),
   .clk_en        (clk_en),
   .upstream_hold (upstream_hold)
);

// File: tb/cgw_ctrl_tb.sv
`timescale 1ns/1ps
module cgw_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       sg_valid = 1'b0;
   logic [2:0] sg_action = '0;
   logic       scd_valid = 1'b0;
   logic       link_stop_n = 1'b1;
   logic       clk_en;
   logic       upstream_hold;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #10 clk = ~clk;

   cgw_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .sg_valid (sg_valid), .sg_action (sg_action), .scd_valid (scd_valid),
      .link_stop_n (link_stop_n), .clk_en (clk_en), .upstream_hold (upstream_hold)
   );

   // behavioural reference: phase 0 idle, 1 window open, 2 hold only, 3 gated, 4 trailing hold
   logic [7:0] m_mask;
   logic [1:0] m_pipe;
   int         m_phase;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask  <= '0;
         m_pipe  <= '0;
         m_phase <= 0;
      end else begin
         automatic bit hit  = sg_valid && m_mask[sg_action];
         automatic bit seen = m_pipe[1];
         m_pipe <= {m_pipe[0], ~link_stop_n};
         if (cfg_we) m_mask <= cfg_wdata;
         if (m_phase == 0) begin
            if (hit && !scd_valid) m_phase <= 1;
         end else if (m_phase == 1) begin
            if (scd_valid) m_phase <= 0;
            else if (seen) m_phase <= 2;
            else if (sg_valid && !hit) m_phase <= 0;
         end else if (m_phase == 2) m_phase <= 3;
         else if (m_phase == 3) begin
            if (!seen) m_phase <= 4;
         end else m_phase <= 0;
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "clk_en vs model", clk_en, (m_phase != 3));
         check(tag, "upstream_hold vs model", upstream_hold, (m_phase >= 2));
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mask(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v; cycles(1); cfg_we = 1'b0;
   endtask

   task automatic stop_grant(input logic [2:0] code, input logic with_rel);
      sg_valid = 1'b1; sg_action = code; scd_valid = with_rel;
      cycles(1);
      sg_valid = 1'b0; scd_valid = 1'b0;
   endtask

   task automatic release_msg();
      scd_valid = 1'b1; cycles(1); scd_valid = 1'b0;
   endtask

   // link-stop low for `len` cycles, then high and settle; returns whether gating was seen
   task automatic stop_pulse(input int len, output bit gated);
      gated = 1'b0;
      link_stop_n = 1'b0;
      for (int i = 0; i < len; i++) begin
         cycles(1);
         if (!clk_en) gated = 1'b1;
      end
      link_stop_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cycles(1);
         if (!clk_en) gated = 1'b1;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit g;
      cycles(2);
      rst_n = 1'b1;
      cycles(1);
      tag = "R1";
      check("R1", "reset clk_en", clk_en, 1'b1);
      check("R1", "reset hold", upstream_hold, 1'b0);
      stop_grant(3'd5, 1'b0);
      stop_pulse(8, g);
      check("R1", "zero mask blocks gating", g, 1'b0);

      tag = "R2";
      write_mask(8'b0010_0000);
      tag = "R4";
      stop_grant(3'd3, 1'b0);
      stop_pulse(8, g);
      check("R4", "disabled code does not gate", g, 1'b0);

      tag = "R6";
      stop_pulse(8, g);
      check("R6", "no window no gating", g, 1'b0);

      tag = "R3";
      stop_grant(3'd5, 1'b0);
      cycles(2);
      link_stop_n = 1'b0;
      cycles(2);
      check("R7", "hold not yet after 2 edges", upstream_hold, 1'b0);
      cycles(1);
      check("R7", "hold after 3rd edge", upstream_hold, 1'b1);
      check("R7", "clk_en still on", clk_en, 1'b1);
      cycles(1);
      check("R3", "gated with window open", clk_en, 1'b0);
      cycles(4);
      tag = "R8";
      link_stop_n = 1'b1;
      cycles(2);
      check("R8", "still gated after 2 edges", clk_en, 1'b0);
      cycles(1);
      check("R8", "clk_en back after 3rd edge", clk_en, 1'b1);
      check("R8", "hold kept one more cycle", upstream_hold, 1'b1);
      cycles(1);
      check("R8", "hold released", upstream_hold, 1'b0);
      cycles(3);

      tag = "R9";
      stop_pulse(8, g);
      check("R9", "second assertion not gated", g, 1'b0);

      tag = "R5";
      stop_grant(3'd5, 1'b0);
      release_msg();
      stop_pulse(8, g);
      check("R5", "release closes window", g, 1'b0);
      stop_grant(3'd5, 1'b1);
      stop_pulse(8, g);
      check("R5", "same-cycle release wins", g, 1'b0);

      tag = "R4";
      stop_grant(3'd5, 1'b0);
      stop_grant(3'd2, 1'b0);
      stop_pulse(8, g);
      check("R4", "disabled code closes open window", g, 1'b0);

      tag = "R10";
      stop_grant(3'd5, 1'b0);
      link_stop_n = 1'b0;
      cycles(4);
      check("R10", "gated before release msg", clk_en, 1'b0);
      release_msg();
      cycles(3);
      check("R10", "release msg does not end gating", clk_en, 1'b0);
      link_stop_n = 1'b1;
      cycles(6);
      check("R10", "gating ended at link release", clk_en, 1'b1);
      stop_pulse(8, g);
      check("R10", "window closed afterwards", g, 1'b0);

      tag = "R2";
      write_mask(8'b0000_1000);
      stop_grant(3'd5, 1'b0);
      stop_pulse(8, g);
      check("R2", "old code no longer enabled", g, 1'b0);
      stop_grant(3'd3, 1'b0);
      stop_pulse(8, g);
      check("R2", "new code enabled", g, 1'b1);
      cfg_we = 1'b1; cfg_wdata = 8'h01; sg_valid = 1'b1; sg_action = 3'd0;
      cycles(1);
      cfg_we = 1'b0; sg_valid = 1'b0;
      stop_pulse(8, g);
      check("R2", "same-cycle write uses old mask", g, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule